// File: doc/BRIEF.md
# Serial DAC Control Front End

This block is the digital side of a 12-bit voltage-output converter. A host writes 16-bit frames over a three-wire serial port made up of an active-low select, a serial clock and a data line. Each frame carries a 4-bit command in its upper nibble and a 12-bit code in its lower bits. The block turns these frames into a held converter code, a general-purpose output level and a software sleep request. It also returns a serial output stream, which allows several devices to be chained or an earlier frame to be read back.

Four pins act alongside the serial port:

- An active-low clear input forces the code to a fixed value.
- A strap picks that value. It is zero when the strap is low and midscale when it is high. The same value is loaded at reset.
- A lockout strap, when low, overrides every shutdown request.
- A hardware shutdown pin puts the block to sleep when the lockout strap allows it.

While asleep, the enable for the analog output stage is dropped.

All serial pins are sampled by the block's own clock through a two-stage synchronizer. The serial stream has no back-pressure: a frame can never be stalled or refused by the block. The host therefore has to keep each level of the serial clock and select lines for at least three periods of the block clock. A frame that breaks the rules is dropped silently.

Top module: `sdac_front`

## Requirements
- R1: When reset is released, `dac_code` is 0x000 if `mid_strap` was low and 0x800 if it was high. `user_out` is low, and the software sleep flag is clear.
- R2: Bits are taken MSB first on each rising `sclk` while `cs_n` is low. A frame acts on the rising edge of `cs_n` only when exactly 16 rising edges were seen since `cs_n` fell. Frames with 15 or 17 edges change nothing.
- R3: While `cs_n` is high, `sclk` and `sdi` activity leaves the shift register untouched, as the next readback shows.
- R4: The command nibble is bits 15..12 and the code is bits 11..0. Command 0x1 loads only the input register. Command 0x2 copies the input register to `dac_code`. Command 0x3 loads both. Code 0xFFF gives full scale.
- R5: Command 0x4 drives `user_out` low and command 0x5 drives it high.
- R6: While `clear_n` is low, both the input register and `dac_code` are held at the strap value (0x000 or 0x800), and any code command is overridden.
- R7: When `sd_allow` is high, a high on `shdn_pin` drops `aout_en`.
- R8: Command 0x6 sets the software sleep flag and command 0x7 clears it. When `sd_allow` is high, a set flag drops `aout_en`.
- R9: When `sd_allow` is low, `aout_en` stays high whatever the states of `shdn_pin` and the sleep flag.
- R10: After each falling `sclk` inside a frame, `sdo` shows the bit that most recently left the MSB of the shift register. Over a full frame, `sdo` therefore returns the previous 16-bit word, MSB first.
- R11: Command 0x0 and commands 0x8 to 0xF change neither `dac_code`, `user_out` nor `aout_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, updated after falling `sclk` |
| clear_n | input | 1 | Clear request, active low |
| mid_strap | input | 1 | Clear/reset value select: low gives zero, high gives midscale |
| sd_allow | input | 1 | Shutdown permit strap; low blocks all shutdown |
| shdn_pin | input | 1 | Hardware shutdown request, active high |
| dac_code | output | 12 | Code presented to the converter |
| aout_en | output | 1 | Analog output enable; low means high impedance |
| user_out | output | 1 | General-purpose output level |

## Verification
Each kind of internal fault shows up at the ports in its own way:

- A wrong bit count or a wrong frame-qualify decision shows up within a few block clocks after `cs_n` rises. Either a short or long frame moves `dac_code`, or a valid frame fails to move it.
- Corruption of the shift register while `cs_n` is high cannot be seen until the next frame. The bench reads the held word back on `sdo` bit by bit to expose it.
- A lost input-register value or a missed clear appears only at the next update command. Sequences therefore pair every load and every clear with a later update.
- A stale sleep flag appears as soon as the lockout strap is raised.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'h0,
    OP_LOAD     = 4'h1,
    OP_UPDATE   = 4'h2,
    OP_LOAD_UPD = 4'h3,
    OP_AUX_LO   = 4'h4,
    OP_AUX_HI   = 4'h5,
    OP_SLEEP    = 4'h6,
    OP_WAKE     = 4'h7
  } op_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] word,
  output logic              frame_go,
  output logic              sclk_fall,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              sdo
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);

  logic cs_q, sclk_q, out_bit;
  logic sclk_rise, cs_fall, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_q & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_q & ~cs_n_s;
  assign cs_fall   = ~cs_n_s & cs_q;
  assign cs_rise   = cs_n_s & ~cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      word     <= '0;
      out_bit  <= 1'b0;
      sdo      <= 1'b0;
      bit_cnt  <= '0;
      frame_go <= 1'b0;
    end else begin
      cs_q     <= cs_n_s;
      sclk_q   <= sclk_s;
      frame_go <= cs_rise && (bit_cnt == CNT_FULL);
      if (cs_fall)
        bit_cnt <= '0;
      else if (sclk_rise && bit_cnt != CNT_MAX)
        bit_cnt <= bit_cnt + 1'b1;
      if (sclk_rise) begin
        out_bit <= word[WORD_W-1];
        word    <= {word[WORD_W-2:0], sdi_s};
      end
      if (sclk_fall)
        sdo <= out_bit;
    end
  end
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CMD_W = 4,
  localparam int WORD_W = CODE_W + CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_go,
  input  logic [WORD_W-1:0] word,
  input  logic              clr_s,
  input  logic              mid_strap,
  input  logic              sd_allow,
  input  logic              shdn_s,
  output logic [CODE_W-1:0] dac_code,
  output logic              user_out,
  output logic              aout_en
);
  logic [CODE_W-1:0] in_reg, clr_val, data;
  logic              sleep_flag;
  op_e               op;

  assign clr_val = mid_strap ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
  assign data    = word[CODE_W-1:0];
  assign op      = op_e'(word[WORD_W-1 -: CMD_W]);
  assign aout_en = !(sd_allow && (shdn_s || sleep_flag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_reg     <= clr_val;
      dac_code   <= clr_val;
      user_out   <= 1'b0;
      sleep_flag <= 1'b0;
    end else begin
      if (frame_go) begin
        case (op)
          OP_LOAD:     in_reg <= data;
          OP_UPDATE:   dac_code <= in_reg;
          OP_LOAD_UPD: begin in_reg <= data; dac_code <= data; end
          OP_AUX_LO:   user_out <= 1'b0;
          OP_AUX_HI:   user_out <= 1'b1;
          OP_SLEEP:    sleep_flag <= 1'b1;
          OP_WAKE:     sleep_flag <= 1'b0;
          default: ;
        endcase
      end
      if (clr_s) begin
        in_reg   <= clr_val;
        dac_code <= clr_val;
      end
    end
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int CODE_W = 12,
  parameter int CMD_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  input  logic              clear_n,
  input  logic              mid_strap,
  input  logic              sd_allow,
  input  logic              shdn_pin,
  output logic [CODE_W-1:0] dac_code,
  output logic              aout_en,
  output logic              user_out
);
  localparam int WORD_W = CODE_W + CMD_W;
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic [4:0]        pins_s;
  logic              cs_n_s, sclk_s, sdi_s, clr_s, shdn_s;
  logic [WORD_W-1:0] word;
  logic              frame_go, sclk_fall;
  logic [CNT_W-1:0]  bit_cnt;

  sdac_sync #(.N(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b10010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, sdi, clear_n, shdn_pin}),
    .q(pins_s)
  );

  assign cs_n_s = pins_s[4];
  assign sclk_s = pins_s[3];
  assign sdi_s  = pins_s[2];
  assign clr_s  = ~pins_s[1];
  assign shdn_s = pins_s[0];

  sdac_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .word(word), .frame_go(frame_go), .sclk_fall(sclk_fall),
    .bit_cnt(bit_cnt), .sdo(sdo)
  );

  sdac_regs #(.CODE_W(CODE_W), .CMD_W(CMD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .frame_go(frame_go), .word(word), .clr_s(clr_s),
    .mid_strap(mid_strap), .sd_allow(sd_allow), .shdn_s(shdn_s),
    .dac_code(dac_code), .user_out(user_out), .aout_en(aout_en)
  );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int CODE_W = 12,
  parameter int WORD_W = 16,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_go,
  input logic              sclk_fall,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              clr_s,
  input logic              shdn_s,
  input logic              sd_allow,
  input logic              mid_strap,
  input logic              sdo,
  input logic [CODE_W-1:0] dac_code,
  input logic              user_out,
  input logic              aout_en
);
  logic [2:0] age;
  logic [CODE_W-1:0] clr_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end

  assign clr_ref = mid_strap ? CODE_W'(1 << (CODE_W - 1)) : '0;

  assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W + 1));

  assert_full_frame_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 0 && frame_go) |-> $past(bit_cnt) == CNT_W'(WORD_W));

  assert_code_moves_on_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 0 && !$stable(dac_code)) |-> $past(frame_go || clr_s));

  assert_aux_moves_on_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 0 && !$stable(user_out)) |-> $past(frame_go));

  assert_clear_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 0 && $past(clr_s)) |-> dac_code == clr_ref);

  assert_hw_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_allow && shdn_s) |-> !aout_en);

  assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_allow |-> aout_en);

  assert_sdo_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 0 && !$stable(sdo)) |-> $past(sclk_fall));
endmodule

bind sdac_front sdac_front_chk #(.CODE_W(CODE_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .sclk_fall(sclk_fall),
  .bit_cnt(bit_cnt), .clr_s(clr_s), .shdn_s(shdn_s), .sd_allow(sd_allow),
  .mid_strap(mid_strap), .sdo(sdo), .dac_code(dac_code),
  .user_out(user_out), .aout_en(aout_en)
);

// File: tb/sdac_front_test.sv
module sdac_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic clear_n = 1'b1, mid_strap = 1'b1, sd_allow = 1'b1, shdn_pin = 1'b0;
  logic sdo, aout_en, user_out;
  logic [11:0] dac_code;
  logic [15:0] rd;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  sdac_front uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .clear_n(clear_n), .mid_strap(mid_strap), .sd_allow(sd_allow),
    .shdn_pin(shdn_pin), .dac_code(dac_code), .aout_en(aout_en),
    .user_out(user_out)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0;
    mid_strap = strap;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  // Sends nbits bits MSB first, padding past 16 with zeros; captures sdo into rd.
  task automatic send(input logic [15:0] w, input int nbits);
    rd = '0;
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(6);
      if (i < 16) rd[15-i] = sdo;
      wait_clk(2);
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic t_reset_mid;
    do_reset(1'b1);
    check("R1 midscale reset code", dac_code, 12'h800);
    check("R1 aux low after reset", user_out, 1'b0);
    check("R1 output enabled after reset", aout_en, 1'b1);
  endtask

  task automatic t_load_update;
    send(16'h13A5, 16);
    check("R4 load only keeps code", dac_code, 12'h800);
    send(16'h2000, 16);
    check("R4 update copies input reg", dac_code, 12'h3A5);
    send(16'h3FFF, 16);
    check("R4 load-and-update full scale", dac_code, 12'hFFF);
  endtask

  task automatic t_frame_len;
    send(16'h3123, 15);
    check("R2 short frame discarded", dac_code, 12'hFFF);
    send(16'h3123, 17);
    check("R2 long frame discarded", dac_code, 12'hFFF);
    send(16'h3123, 16);
    check("R2 exact frame accepted", dac_code, 12'h123);
  endtask

  task automatic t_cs_high_hold;
    send(16'h15A5, 16);
    sdi = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_clk(8); sclk = 1'b1; wait_clk(8); sclk = 1'b0;
    end
    wait_clk(8);
    sdi = 1'b0;
    send(16'h0000, 16);
    check("R3 register held while deselected", rd, 16'h15A5);
    check("R11 no-op leaves code", dac_code, 12'h123);
  endtask

  task automatic t_readback;
    send(16'h8ABC, 16);
    check("R11 reserved op leaves code", dac_code, 12'h123);
    send(16'h0000, 16);
    check("R10 readback of previous word", rd, 16'h8ABC);
    send(16'h2000, 16);
    check("R4 input reg from earlier load", dac_code, 12'h5A5);
  endtask

  task automatic t_aux;
    send(16'h5000, 16);
    check("R5 aux high", user_out, 1'b1);
    send(16'hF000, 16);
    check("R11 reserved op keeps aux", user_out, 1'b1);
    send(16'h4000, 16);
    check("R5 aux low", user_out, 1'b0);
  endtask

  task automatic t_clear;
    clear_n = 1'b0;
    wait_clk(6);
    check("R6 clear to midscale", dac_code, 12'h800);
    send(16'h3456, 16);
    check("R6 clear overrides load", dac_code, 12'h800);
    clear_n = 1'b1;
    wait_clk(6);
    send(16'h2000, 16);
    check("R6 input reg cleared too", dac_code, 12'h800);
  endtask

  task automatic t_shutdown;
    sd_allow = 1'b1; shdn_pin = 1'b1; wait_clk(6);
    check("R7 pin shutdown", aout_en, 1'b0);
    shdn_pin = 1'b0; wait_clk(6);
    check("R7 pin release", aout_en, 1'b1);
    sd_allow = 1'b0; shdn_pin = 1'b1; wait_clk(6);
    check("R9 lockout blocks pin", aout_en, 1'b1);
    shdn_pin = 1'b0; wait_clk(6);
    send(16'h6000, 16);
    check("R9 lockout blocks sleep cmd", aout_en, 1'b1);
    sd_allow = 1'b1; wait_clk(2);
    check("R8 stored sleep takes effect", aout_en, 1'b0);
    send(16'h7000, 16);
    check("R8 wake cmd", aout_en, 1'b1);
  endtask

  task automatic t_reset_zero;
    do_reset(1'b0);
    check("R1 zero reset code", dac_code, 12'h000);
    check("R1 aux low after second reset", user_out, 1'b0);
    check("R1 sleep flag clear after reset", aout_en, 1'b1);
    send(16'h3777, 16);
    check("R4 load-and-update after reset", dac_code, 12'h777);
    clear_n = 1'b0; wait_clk(6);
    check("R6 clear to zero", dac_code, 12'h000);
    clear_n = 1'b1; wait_clk(6);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_mid();
    t_load_update();
    t_frame_len();
    t_cs_high_hold();
    t_readback();
    t_aux();
    t_clear();
    t_shutdown();
    t_reset_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule